// File: doc/BRIEF.md
# Self-Synchronizing Nibble Read Deserializer

This block turns the serial bit stream recovered from a disk read channel into bytes that a slow polling reader can pick up. One bit arrives per bit cell. A sequencer clock enable and a bit-cell strobe mark the sampling instant. Each sampled bit is shifted into an 8-bit register at the least significant end. A nibble is complete once the register's top bit reads 1.

When a nibble completes, the register freezes for a fixed number of enabled sequencer cycles. The default is 16, which is two bit cells. This gives a reader that polls once every few cycles a stable byte to sample. Bits that arrive during the freeze are collected on the side and become the start of the next nibble when the freeze ends, so none are lost.

A zero bit that arrives while no nibble has started is discarded. Because of this, any number of gap zeros may separate nibbles. A run of sync nibbles (eight ones followed by one or two zeros) then forces the reader into byte alignment within a bounded number of nibbles, wherever it started reading.

Top module: `ssn_reader`

## Requirements
- R1: A synchronous reset on `rst` clears `nib_data` to 0x00 and holds `nib_valid` and `nib_strobe` low in the cycle that follows.
- R2: A bit is sampled only on a clock edge where `seq_en` and `bit_stb` are both 1. It enters at bit 0 and older bits move toward bit 7. If either input is 0, the register does not change.
- R3: A 0 that is sampled while `nib_data` is 0x00 and no hold is running is discarded, and the register stays 0x00.
- R4: When a sampled bit sets bit 7, the completed byte appears on `nib_data` after that edge. `nib_valid` goes high together with it, and `nib_strobe` is high for exactly that one clock. `nib_valid` is high exactly when bit 7 of `nib_data` is 1.
- R5: After completion, `nib_data` is frozen and `nib_valid` stays high for exactly HOLD_CLKS (default 16) clock edges with `seq_en` = 1.
- R6: Bits sampled during the hold are kept, with leading zeros dropped. On the edge that ends the hold, `nib_data` takes them as the partial next nibble (for example, bits 1 then 0 give 0x02).
- R7: For a repeated 9-bit sync pattern (eight 1s then one 0), whatever the starting bit offset, every nibble from the eighth onward is 0xFF. Starting two bits into the pattern gives 0xFD, 0xFE, 0xFF.
- R8: For a repeated 10-bit sync pattern (eight 1s then two 0s), every nibble from the fifth onward is 0xFF. Starting three bits into the pattern gives 0xF9, 0xFE, 0xFF.
- R9: The hold counts only edges where `seq_en` is 1. Cycles with `seq_en` = 0 lengthen the hold in clock time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_en | input | 1 | Sequencer clock enable |
| bit_stb | input | 1 | Bit-cell sampling strobe, one per 8 enabled cycles |
| bit_in | input | 1 | Recovered read bit |
| nib_data | output | 8 | Data register contents |
| nib_strobe | output | 1 | One-clock pulse when a nibble completes |
| nib_valid | output | 1 | High for the whole hold interval |

## Verification
A wrong hold count shows up at the ports in one of two ways. Either the time `nib_valid` stays high in enabled cycles is off, or `nib_valid` disagrees with bit 7 of `nib_data`; either is visible on the very edge the count goes wrong. A lost or duplicated bit in the side collector is not visible right away. It changes the value of the next completed nibble, so the bench compares every strobed byte with a byte list parsed from the stream it sent. A sync test started at every bit offset would also show a missing zero-drop, because the stream would never settle on 0xFF.

// File: rtl/ssn_pkg.sv
package ssn_pkg;
  localparam int NIB_W = 8;
  typedef logic [NIB_W-1:0] nib_t;

  // append one bit at the low end, dropping it when it is a leading zero
  function automatic nib_t shift_keep(input nib_t cur, input logic b);
    if (cur == '0 && !b) return '0;
    return {cur[NIB_W-2:0], b};
  endfunction

  function automatic logic is_full(input nib_t cur);
    return cur[NIB_W-1];
  endfunction
endpackage

// File: rtl/ssn_hold_timer.sv
module ssn_hold_timer #(
  parameter int HOLD_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_en,
  input  logic load,
  output logic active,
  output logic release_o
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] HOLD_VAL = CW'(HOLD_CLKS);

  logic [CW-1:0] cnt_q;

  assign active    = (cnt_q != '0);
  assign release_o = seq_en && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= HOLD_VAL;
    else if (seq_en && active) cnt_q <= cnt_q - CW'(1);
  end

  assert_hold_load_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == HOLD_VAL));

  assert_hold_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (!seq_en && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ssn_pending.sv
module ssn_pending
  import ssn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic bit_in,
  input  logic clear,
  output nib_t acc_next
);
  nib_t acc_q;
  logic take;

  assign take     = capture && !is_full(acc_q);
  assign acc_next = take ? shift_keep(acc_q, bit_in) : acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (take)    acc_q <= acc_next;
  end

  assert_pend_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (capture && !bit_in && acc_q == '0 && !clear) |=> (acc_q == '0));
endmodule

// File: rtl/ssn_front.sv
module ssn_front
  import ssn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  input  logic reload,
  input  nib_t reload_val,
  output nib_t data_q,
  output logic fills
);
  nib_t shifted;

  assign shifted = shift_keep(data_q, bit_in);
  assign fills   = shift_en && is_full(shifted);

  always_ff @(posedge clk) begin
    if (rst)           data_q <= '0;
    else if (shift_en) data_q <= shifted;
    else if (reload)   data_q <= reload_val;
  end

  assert_zero_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !bit_in && data_q == '0) |=> (data_q == '0));
endmodule

// File: rtl/ssn_reader.sv
module ssn_reader
  import ssn_pkg::*;
#(
  parameter int HOLD_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seq_en,
  input  logic       bit_stb,
  input  logic       bit_in,
  output logic [7:0] nib_data,
  output logic       nib_strobe,
  output logic       nib_valid
);
  logic samp, hold_active, hold_release, front_shift, pend_cap;
  logic front_fills, load, strobe_q;
  nib_t data_q, pend_next;

  assign samp        = seq_en && bit_stb;
  assign front_shift = samp && !hold_active;
  assign pend_cap    = samp && hold_active;
  assign load        = front_fills || (hold_release && is_full(pend_next));

  ssn_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_timer (
    .clk(clk), .rst(rst), .seq_en(seq_en), .load(load),
    .active(hold_active), .release_o(hold_release)
  );

  ssn_pending u_pend (
    .clk(clk), .rst(rst), .capture(pend_cap), .bit_in(bit_in),
    .clear(hold_release), .acc_next(pend_next)
  );

  ssn_front u_front (
    .clk(clk), .rst(rst), .shift_en(front_shift), .bit_in(bit_in),
    .reload(hold_release), .reload_val(pend_next),
    .data_q(data_q), .fills(front_fills)
  );

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= load;
  end

  assign nib_data   = data_q;
  assign nib_strobe = strobe_q;
  assign nib_valid  = hold_active;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (nib_data == 8'h00 && !nib_valid && !nib_strobe));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!samp && !hold_release) |=> $stable(nib_data));

  assert_strobe_full_R4: assert property (@(posedge clk) disable iff (rst)
    nib_strobe |-> (nib_valid && nib_data[7]));

  assert_valid_msb_R4: assert property (@(posedge clk) disable iff (rst)
    nib_valid == nib_data[7]);

  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_active && !hold_release) |=> $stable(nib_data));
endmodule

// File: tb/ssn_reader_bench.sv
module ssn_reader_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_en = 1'b0, bit_stb = 1'b0, bit_in = 1'b0;
  logic [7:0] nib_data;
  logic nib_strobe, nib_valid;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  bit sent[$];
  logic [7:0] got[$];
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  ssn_reader u_ssn_reader (
    .clk(clk), .rst(rst), .seq_en(seq_en), .bit_stb(bit_stb), .bit_in(bit_in),
    .nib_data(nib_data), .nib_strobe(nib_strobe), .nib_valid(nib_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  bit prev_valid = 0, prev_strobe = 0;
  logic [7:0] prev_data = 0;
  int en_cnt = 0;
  always @(posedge clk) begin
    #2;
    if (rst) begin
      prev_valid = 0; prev_strobe = 0; en_cnt = 0;
    end else begin
      if (prev_valid && seq_en) en_cnt++;
      if (nib_strobe) begin
        got.push_back(nib_data);
        chk(nib_valid && nib_data[7], "R4 strobe with full byte", {nib_valid, nib_data}, 9'h180);
        chk(!prev_strobe, "R4 strobe one clock", prev_strobe, 0);
      end
      if (prev_valid && nib_valid && !nib_strobe && prev_data != nib_data)
        chk(0, "R5 frozen data", nib_data, prev_data);
      if (prev_valid && !nib_valid) begin
        chk(en_cnt == 16, "R5 R9 hold length", en_cnt, 16);
        en_cnt = 0;
      end
      prev_valid = nib_valid; prev_strobe = nib_strobe; prev_data = nib_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input bit en, input bit stb, input bit b);
    @(negedge clk);
    seq_en = en; bit_stb = stb; bit_in = b;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  // one bit cell: eight enabled cycles, strobe on the last, random idle gaps
  task automatic send_bit(input bit b, input int dens);
    for (int i = 0; i < 8; i++) begin
      while ($urandom_range(0, 99) >= dens) tick(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      tick(1, i == 7, (i == 7) ? b : 1'b0);
    end
    sent.push_back(b);
  endtask

  task automatic send_byte(input logic [7:0] v, input int dens);
    for (int i = 7; i >= 0; i--) send_bit(v[i], dens);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; seq_en = 0; bit_stb = 0; bit_in = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    sent.delete(); got.delete();
  endtask

  // expected nibbles: skip zeros until a 1, then take eight bits
  task automatic build_expected();
    logic [7:0] cur;
    int n;
    expq.delete();
    cur = 0; n = 0;
    foreach (sent[i]) begin
      if (n == 0 && !sent[i]) continue;
      cur = {cur[6:0], sent[i]};
      n++;
      if (n == 8) begin expq.push_back(cur); n = 0; cur = 0; end
    end
  endtask

  task automatic end_phase(input string tag);
    repeat (24) tick(1, 0, 0);
    settle();
    build_expected();
    chk(got.size() == expq.size(), {tag, " nibble count"}, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      chk(got[i] == expq[i], tag, got[i], expq[i]);
  endtask

  initial begin
    do_reset();
    settle();
    chk(nib_data == 8'h00 && !nib_valid && !nib_strobe, "R1 reset state", nib_data, 0);

    // R2: strobe without enable, enable without strobe
    tick(0, 1, 1); settle();
    chk(nib_data == 8'h00, "R2 strobe ignored without enable", nib_data, 0);
    tick(1, 0, 1); settle();
    chk(nib_data == 8'h00, "R2 enable alone ignored", nib_data, 0);
    // R3: leading zeros dropped
    send_bit(0, 100); send_bit(0, 100); settle();
    chk(nib_data == 8'h00, "R3 leading zeros dropped", nib_data, 0);
    send_bit(1, 100); settle();
    chk(nib_data == 8'h01, "R2 first bit at LSB", nib_data, 1);
    send_bit(0, 100); send_bit(1, 100); settle();
    chk(nib_data == 8'h05, "R2 shift order", nib_data, 5);
    end_phase("R2 phase");

    // R6: bits during hold carried into next nibble
    do_reset();
    send_byte(8'hFF, 100);
    settle();
    chk(nib_valid && nib_data == 8'hFF, "R4 completed byte visible", nib_data, 8'hFF);
    send_bit(1, 100); send_bit(0, 100);
    repeat (4) tick(1, 0, 0);
    settle();
    chk(nib_data == 8'h02 && !nib_valid, "R6 carried bits", nib_data, 2);
    end_phase("R6 phase");

    // R9: hold stretched by disabled cycles
    do_reset();
    send_byte(8'hD5, 30);
    end_phase("R9 sparse enable");

    // R7: 9-bit sync at every offset
    for (int k = 0; k < 9; k++) begin
      do_reset();
      for (int r = 0; r < 10; r++)
        for (int j = 0; j < 9; j++)
          if (r * 9 + j >= k) send_bit(j < 8, 80);
      end_phase("R7 sync9 stream");
      for (int i = 7; i < got.size(); i++)
        chk(got[i] == 8'hFF, "R7 aligned by eighth nibble", got[i], 8'hFF);
      if (k == 2)
        chk(got.size() >= 3 && got[0] == 8'hFD && got[1] == 8'hFE && got[2] == 8'hFF,
            "R7 offset two gives FD FE FF", got[0], 8'hFD);
    end

    // R8: 10-bit sync at every offset
    for (int k = 0; k < 10; k++) begin
      do_reset();
      for (int r = 0; r < 8; r++)
        for (int j = 0; j < 10; j++)
          if (r * 10 + j >= k) send_bit(j < 8, 80);
      end_phase("R8 sync10 stream");
      for (int i = 4; i < got.size(); i++)
        chk(got[i] == 8'hFF, "R8 aligned by fifth nibble", got[i], 8'hFF);
      if (k == 3)
        chk(got.size() >= 3 && got[0] == 8'hF9 && got[1] == 8'hFE && got[2] == 8'hFF,
            "R8 offset three gives F9 FE FF", got[0], 8'hF9);
    end

    // random nibbles with random zero gaps and enable density
    void'($urandom(32'd12345));
    do_reset();
    for (int n = 0; n < 150; n++) begin
      logic [7:0] v;
      int gap;
      v = 8'($urandom_range(0, 255)) | 8'h80;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) send_bit(0, 90);
      send_byte(v, $urandom_range(40, 100));
    end
    end_phase("R4 R6 random stream");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule